// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Unit

This block sits beside one processor on a shared, snooped bus and implements the reservation half of a load-reserve / store-conditional atomic pair. A load-reserve reads memory like an ordinary load and also arms a single reservation that covers the cache line holding the address. A later store-conditional to the same line is sent to the bus as a normal store only if that reservation is still armed. Otherwise it is dropped and reported as a failure. The pass/fail result of the most recent store-conditional stays on a status output until the next one.

The unit watches the bus for stores made by other agents. A store seen there that touches the reserved line disarms the reservation. A successful store-conditional reaches the bus as an ordinary store, so every other unit on the bus that snoops it drops its own reservation on that line. Several units may hold reservations on the same line at once. Plain loads and stores pass straight through. Memory sits outside the block and returns read data combinationally on `bus_rdata`.

Operation codes on `req_op`: 2'b00 load, 2'b01 store, 2'b10 load-reserve, 2'b11 store-conditional. Bit 0 set means a write. `OFF_BITS` low address bits select a word within a line.

Top module: `lrsc_resv_unit`

## Requirements
- R1: During reset and straight after it, `sc_ok` and `rsp_valid` are 0 and no reservation is held. A store-conditional issued with no earlier load-reserve fails.
- R2: A load or store drives `bus_valid` in the same cycle, with `bus_write` equal to `req_op[0]` and with `bus_addr` and `bus_wdata` copied from the request. A load, or a load-reserve, raises `rsp_valid` for one cycle after the clock edge, with `rsp_rdata` holding the word read. A store does not raise `rsp_valid`.
- R3: A load-reserve produces the same bus read as a load, records the line of its address and arms the reservation.
- R4: A store-conditional passes when the reservation is armed, its line matches, and no conflicting snoop arrives in the same cycle. A passing store-conditional issues a bus store in the same cycle, and `sc_ok` reads 1 after the edge. That bus store cancels a matching reservation held by another unit.
- R5: A failing store-conditional issues no bus transaction, so memory is unchanged, and `sc_ok` reads 0 after the edge.
- R6: Addresses are matched by line. Two addresses that differ only in their low `OFF_BITS` bits match, and two addresses in different lines do not.
- R7: A snooped store (`snoop_valid`) whose line equals the reserved line disarms the reservation. A snooped store to any other line leaves the reservation armed.
- R8: Every store-conditional disarms the local reservation, whether it passes or fails.
- R9: A snooped store to the reserved line that arrives in the same cycle as a store-conditional makes the store-conditional fail.
- R10: `sc_ok` changes only on a store-conditional. Loads, stores and load-reserves leave it as it was.
- R11: A load-reserve always arms the reservation, even when a snooped store to the same line arrives in the same cycle. A new load-reserve replaces the line that was reserved before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present this cycle |
| req_op | input | 2 | Operation code (see above) |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Write data for store and store-conditional |
| snoop_valid | input | 1 | A store by another agent is on the bus |
| snoop_addr | input | AW | Address of the snooped store |
| bus_valid | output | 1 | Bus transaction issued this cycle |
| bus_write | output | 1 | Issued transaction is a store |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Read data returned by memory in the same cycle |
| rsp_valid | output | 1 | Read data valid, one cycle after a load or load-reserve |
| rsp_rdata | output | DW | Read data returned to the processor |
| sc_ok | output | 1 | Result of the last store-conditional (1 = passed) |

## Verification
The bus outputs follow the request combinationally. The bench therefore checks `bus_valid`, `bus_write` and `bus_addr` one time unit after it drives the request on a falling edge, well before the next rising edge. `rsp_valid`, `rsp_rdata` and `sc_ok` are registered and change on the rising edge after the request. They are checked on the next falling edge, and the request is then withdrawn. The reservation flag is not a port, so its state is read back through a later store-conditional: whether that store-conditional reaches the bus in the same cycle, and what `sc_ok` shows one edge later. A second unit on the same bus snoops the first unit's stores, which shows the effect of a passing store-conditional on another unit.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LRSV  = 2'b10,
      OP_SCOND = 2'b11
   } lrsc_op_e;
endpackage

// File: rtl/lrsc_line_cmp.sv
// Compares the line part of a word address with a stored line number.
module lrsc_line_cmp #(
   parameter int AW       = 32,
   parameter int OFF_BITS = 4,
   localparam int LW      = AW - OFF_BITS
) (
   input  logic [AW-1:0] addr,
   input  logic [LW-1:0] line,
   output logic          hit
);
   generate
      if (OFF_BITS == 0) begin : g_word
         assign hit = (addr == line);
      end else begin : g_line
         wire unused_off = ^addr[OFF_BITS-1:0];
         assign hit = (addr[AW-1:OFF_BITS] == line);
      end
   endgenerate
endmodule

// File: rtl/lrsc_resv_reg.sv
// Reservation flag and reserved line; arming takes priority over disarming.
module lrsc_resv_reg #(
   parameter int LW = 28
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic [LW-1:0] arm_line,
   input  logic          disarm,
   output logic          vld,
   output logic [LW-1:0] line
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         line <= '0;
      end else if (arm) begin
         vld  <= 1'b1;
         line <= arm_line;
      end else if (disarm) begin
         vld  <= 1'b0;
      end
   end
endmodule

// File: rtl/lrsc_status_reg.sv
// Holds the outcome of the most recent store-conditional.
module lrsc_status_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic pass,
   output logic ok
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ok <= 1'b0;
      else if (upd) ok <= pass;
   end
endmodule

// File: rtl/lrsc_rsp_reg.sv
// Registers read data for loads and load-reserves.
module lrsc_rsp_reg #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd,
   input  logic [DW-1:0] rd_data,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd;
         if (rd) rsp_rdata <= rd_data;
      end
   end
endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit
   import lrsc_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int OFF_BITS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          snoop_valid,
   input  logic [AW-1:0] snoop_addr,
   output logic          bus_valid,
   output logic          bus_write,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          sc_ok
);
   localparam int LW = AW - OFF_BITS;

   generate
      if (OFF_BITS < 0 || OFF_BITS >= AW || DW < 1) begin : g_bad_param
         initial $fatal(1, "lrsc_resv_unit: OFF_BITS must lie in [0, AW) and DW must be positive");
      end
   endgenerate

   lrsc_op_e      op;
   logic          is_lr, is_sc, is_rd;
   logic          resv_vld;
   logic [LW-1:0] resv_line;
   logic          req_hit, snp_hit, snp_kill, sc_pass;

   assign op    = lrsc_op_e'(req_op);
   assign is_lr = req_valid && (op == OP_LRSV);
   assign is_sc = req_valid && (op == OP_SCOND);
   assign is_rd = req_valid && (op == OP_LOAD || op == OP_LRSV);

   lrsc_line_cmp #(.AW(AW), .OFF_BITS(OFF_BITS)) u_req_cmp (
      .addr(req_addr), .line(resv_line), .hit(req_hit)
   );

   lrsc_line_cmp #(.AW(AW), .OFF_BITS(OFF_BITS)) u_snp_cmp (
      .addr(snoop_addr), .line(resv_line), .hit(snp_hit)
   );

   // A store from another agent to the reserved line beats a local conditional store.
   assign snp_kill = snoop_valid && snp_hit;
   assign sc_pass  = is_sc && resv_vld && req_hit && !snp_kill;

   lrsc_resv_reg #(.LW(LW)) u_resv (
      .clk(clk), .rst_n(rst_n),
      .arm(is_lr), .arm_line(req_addr[AW-1:OFF_BITS]),
      .disarm(snp_kill || is_sc),
      .vld(resv_vld), .line(resv_line)
   );

   lrsc_status_reg u_status (
      .clk(clk), .rst_n(rst_n), .upd(is_sc), .pass(sc_pass), .ok(sc_ok)
   );

   lrsc_rsp_reg #(.DW(DW)) u_rsp (
      .clk(clk), .rst_n(rst_n), .rd(is_rd), .rd_data(bus_rdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   // Conditional stores reach the bus only when they pass; the rest go straight out.
   assign bus_valid = req_valid && (!is_sc || sc_pass);
   assign bus_write = bus_valid && req_op[0];
   assign bus_addr  = req_addr;
   assign bus_wdata = req_wdata;
endmodule

// File: rtl/lrsc_resv_chk.sv
module lrsc_resv_chk #(
   parameter int AW       = 32,
   parameter int OFF_BITS = 4,
   localparam int LW      = AW - OFF_BITS
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [1:0]    req_op,
   input logic          snoop_valid,
   input logic [LW-1:0] snoop_line,
   input logic          bus_valid,
   input logic          rsp_valid,
   input logic          sc_ok,
   input logic          resv_vld,
   input logic [LW-1:0] resv_line
);
   logic c_sc, c_lr, c_rd;
   assign c_sc = req_valid && (req_op == 2'b11);
   assign c_lr = req_valid && (req_op == 2'b10);
   assign c_rd = req_valid && !req_op[0];

   AST_SC_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc && !resv_vld |-> !bus_valid); // R5
   AST_SC_PASS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc && bus_valid |=> sc_ok); // R4
   AST_SC_FAIL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc && !bus_valid |=> !sc_ok); // R5
   AST_SC_CLEARS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc |=> !resv_vld); // R8
   AST_LR_ARMS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      c_lr |=> resv_vld); // R3
   AST_SNOOP_KILLS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid && resv_vld && (snoop_line == resv_line) && !c_lr |=> !resv_vld); // R7
   AST_SNOOP_BEATS_SC: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc && snoop_valid && resv_vld && (snoop_line == resv_line) |-> !bus_valid); // R9
   AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd |=> rsp_valid); // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !c_rd |=> !rsp_valid); // R2
   AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !c_sc |=> $stable(sc_ok)); // R10
endmodule

bind lrsc_resv_unit lrsc_resv_chk #(.AW(AW), .OFF_BITS(OFF_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .snoop_valid(snoop_valid), .snoop_line(snoop_addr[AW-1:OFF_BITS]),
   .bus_valid(bus_valid), .rsp_valid(rsp_valid), .sc_ok(sc_ok),
   .resv_vld(resv_vld), .resv_line(resv_line)
);

// File: tb/tb_lrsc_resv_unit.sv
module tb_lrsc_resv_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int OB = 2;

   typedef struct packed {
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [7:0]  addr;
      logic [15:0] wd;
      logic        sv;
      logic [7:0]  sa;
      logic        ebus;
      logic        ewr;
      logic        eok;
      logic        erv;
      logic [15:0] erd;
   } vec_t;

   localparam int NV = 24;
   // Memory starts with mem[i] = 16'h1000 + i. Ops: 0 load, 1 store, 2 load-reserve, 3 store-conditional.
   localparam vec_t VECS [NV] = '{
      '{4'd1,  2'd3, 8'h10, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1 SC without LR
      '{4'd2,  2'd0, 8'h21, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1021}, // R2 load
      '{4'd2,  2'd1, 8'h21, 16'hAAAA, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000}, // R2 store
      '{4'd2,  2'd0, 8'h21, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'hAAAA}, // R2 read back
      '{4'd3,  2'd2, 8'h40, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1040}, // R3 LR
      '{4'd6,  2'd3, 8'h43, 16'h5555, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000}, // R4 R6 same line
      '{4'd8,  2'd3, 8'h40, 16'h6666, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8 second SC
      '{4'd10, 2'd0, 8'h43, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h5555}, // R10 R5 memory
      '{4'd3,  2'd2, 8'h44, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1044}, // R3
      '{4'd6,  2'd3, 8'h48, 16'hBEEF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6 other line
      '{4'd3,  2'd2, 8'h44, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1044}, // R3
      '{4'd7,  2'd0, 8'h50, 16'h0000, 1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1050}, // R7 foreign line
      '{4'd7,  2'd3, 8'h45, 16'h7777, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000}, // R7 survived
      '{4'd10, 2'd1, 8'h60, 16'h0001, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000}, // R10 store keeps ok
      '{4'd3,  2'd2, 8'h80, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1080}, // R10 LR keeps ok
      '{4'd7,  2'd0, 8'h00, 16'h0000, 1'b1, 8'h82, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1000}, // R7 snoop kills
      '{4'd7,  2'd3, 8'h80, 16'h2222, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R7 SC fails
      '{4'd3,  2'd2, 8'h84, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1084}, // R3
      '{4'd9,  2'd3, 8'h84, 16'h9999, 1'b1, 8'h86, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R9 collision
      '{4'd11, 2'd2, 8'h88, 16'h0000, 1'b1, 8'h88, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1088}, // R11 LR vs snoop
      '{4'd11, 2'd3, 8'h8B, 16'h1234, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000}, // R11 LR held
      '{4'd11, 2'd2, 8'h90, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1090}, // R11
      '{4'd11, 2'd2, 8'hA0, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h10A0}, // R11 replace
      '{4'd11, 2'd3, 8'h90, 16'h4444, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}  // R11 old line gone
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // unit under test
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ext_sv = 1'b0;
   logic [AW-1:0] ext_sa = '0;
   logic          snoop_valid;
   logic [AW-1:0] snoop_addr;
   logic          bus_valid, bus_write, rsp_valid, sc_ok;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata, rsp_rdata;

   // second unit on the same bus
   logic          p_req_valid = 1'b0;
   logic [1:0]    p_req_op = '0;
   logic [AW-1:0] p_req_addr = '0;
   logic [DW-1:0] p_req_wdata = '0;
   logic          p_bus_valid, p_bus_write, p_rsp_valid, p_sc_ok;
   logic [AW-1:0] p_bus_addr;
   logic [DW-1:0] p_bus_wdata, p_bus_rdata, p_rsp_rdata;

   logic [DW-1:0] mem [256];

   assign snoop_valid = ext_sv | (p_bus_valid & p_bus_write);
   assign snoop_addr  = ext_sv ? ext_sa : p_bus_addr;
   assign bus_rdata   = mem[bus_addr];
   assign p_bus_rdata = mem[p_bus_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 16'h1000 + 16'(i);
      end else begin
         if (bus_valid && bus_write) mem[bus_addr] <= bus_wdata;
         if (p_bus_valid && p_bus_write) mem[p_bus_addr] <= p_bus_wdata;
      end
   end

   lrsc_resv_unit #(.AW(AW), .DW(DW), .OFF_BITS(OB)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sc_ok(sc_ok)
   );

   lrsc_resv_unit #(.AW(AW), .DW(DW), .OFF_BITS(OB)) peer (
      .clk(clk), .rst_n(rst_n), .req_valid(p_req_valid), .req_op(p_req_op),
      .req_addr(p_req_addr), .req_wdata(p_req_wdata),
      .snoop_valid(bus_valid & bus_write), .snoop_addr(bus_addr),
      .bus_valid(p_bus_valid), .bus_write(p_bus_write), .bus_addr(p_bus_addr),
      .bus_wdata(p_bus_wdata), .bus_rdata(p_bus_rdata),
      .rsp_valid(p_rsp_valid), .rsp_rdata(p_rsp_rdata), .sc_ok(p_sc_ok)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic do_op(input vec_t v);
      @(negedge clk);
      req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_wdata = v.wd;
      ext_sv = v.sv; ext_sa = v.sa;
      #1;
      chk(int'(v.rq), "bus_valid", 32'(bus_valid), 32'(v.ebus));
      if (v.ebus) begin
         chk(int'(v.rq), "bus_write", 32'(bus_write), 32'(v.ewr));
         chk(int'(v.rq), "bus_addr", 32'(bus_addr), 32'(v.addr));
      end
      @(negedge clk);
      chk(int'(v.rq), "rsp_valid", 32'(rsp_valid), 32'(v.erv));
      if (v.erv) chk(int'(v.rq), "rsp_rdata", 32'(rsp_rdata), 32'(v.erd));
      chk(int'(v.rq), "sc_ok", 32'(sc_ok), 32'(v.eok));
      req_valid = 1'b0; ext_sv = 1'b0;
   endtask

   task automatic peer_op(input int rq, input logic [1:0] op, input logic [7:0] a,
                          input logic ebus, input logic eok);
      @(negedge clk);
      p_req_valid = 1'b1; p_req_op = op; p_req_addr = a; p_req_wdata = 16'hCAFE;
      #1;
      chk(rq, "peer bus_valid", 32'(p_bus_valid), 32'(ebus));
      @(negedge clk);
      chk(rq, "peer sc_ok", 32'(p_sc_ok), 32'(eok));
      p_req_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: outputs in reset
      chk(1, "sc_ok in reset", 32'(sc_ok), 32'd0);
      chk(1, "rsp_valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) do_op(VECS[i]);

      // R3 R4: both units reserve the same line; the passing store cancels the peer
      do_op('{4'd3, 2'd2, 8'hD0, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h10D0});
      peer_op(3, 2'd2, 8'hD1, 1'b1, 1'b0);
      do_op('{4'd4, 2'd3, 8'hD2, 16'h3C3C, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0});
      peer_op(4, 2'd3, 8'hD0, 1'b0, 1'b0);
      do_op('{4'd4, 2'd0, 8'hD0, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h10D0});
      do_op('{4'd4, 2'd0, 8'hD2, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h3C3C});

      // R1: reset in mid-run drops status and reservation
      do_op('{4'd1, 2'd2, 8'hC0, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h10C0});
      do_op('{4'd1, 2'd3, 8'hC0, 16'h5A5A, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0});
      do_op('{4'd1, 2'd2, 8'hC0, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h5A5A});
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(1, "sc_ok after reset", 32'(sc_ok), 32'd0);
      chk(1, "rsp_valid after reset", 32'(rsp_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      do_op('{4'd1, 2'd3, 8'hC0, 16'h1111, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0});

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule